// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a registered read path and a two-bit burst address generator. An access starts when either of two address strobes (one driven by a processor, one by a cache controller) is low while the chip enable is low. The address is captured on that edge. Each clock edge after it closes one data cycle for the current burst address. A data cycle is either a read, whose word leaves through the output register on that same edge, or a byte-masked write of the data presented on that edge. The burst address steps on each edge where the advance input is low. The step follows a linear or an interleaved order that is latched when the access starts.

The write decision is taken late. The write strobes travel with the data and are sampled on the edge that closes the data cycle, not on the address edge. A global write strobe writes every lane. Otherwise a byte-write enable gates the per-lane selects. The data output is paired with a drive-enable output. That enable rises one edge after a read cycle, falls on write cycles and after a deselect, and is gated combinationally by the output enable. A sleep input ends any access and blocks new ones. The array keeps its contents while asleep.

Top module: `burst_sram`

## Requirements
- R1: After the synchronous active-high reset, no access is active and `dq_oe` is 0 even with `oe_n` low.
- R2: An edge with `ce_n` low, `sleep` low and `astb_cpu_n` or `astb_ctl_n` low captures `addr` with burst count 0. If the next data cycle is a read, the word at that address is on `dout` with `dq_oe` high after the following edge.
- R3: The burst count advances by one only on edges where `adv_n` is low. With `adv_n` high the same address is reused, so the same word repeats on consecutive read cycles.
- R4: In linear order (`order_lin`=1 at the start edge), address bits [1:0] of count k are the start bits plus k modulo 4. Bits above bit 1 never change during a burst, and the fifth word wraps back to the start address.
- R5: In interleaved order (`order_lin`=0 at the start edge), address bits [1:0] of count k are the start bits XOR k. Changing `order_lin` after the start edge has no effect on the running burst.
- R6: `gw_n` low during a data cycle writes all lanes of `din`, regardless of `bwe_n` and `bsel_n`.
- R7: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8..9i) is written exactly when `bsel_n[i]` is low. With `bwe_n` high, or with no lane selected, the data cycle is a read and the array is unchanged.
- R8: With DW=18 there are two lanes (bits 8..0 and 17..9). `bsel_n[3:2]` are ignored, so a cycle that selects only those lanes is a read.
- R9: Write strobes present on the address-capture edge do not write. The write decision and `din` are sampled on the edge that closes the data cycle.
- R10: `dq_oe` follows `oe_n` combinationally, without waiting for a clock edge.
- R11: An edge with a strobe low and `ce_n` high ends the burst. The data cycle closed on that edge still delivers its word, and `dq_oe` is low from the next edge on.
- R12: `sleep` high ends a burst like a deselect does, and no strobe starts an access while it is high. Array contents are kept.
- R13: A strobe during a running burst aborts it and reloads the counter from `addr`. The new start address is read on the next data cycle.
- R14: `dq_oe` is low after any edge that closes a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address captured on a start edge |
| ce_n | input | 1 | Chip enable, active low |
| astb_cpu_n | input | 1 | Processor address strobe, active low |
| astb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved (latched at start) |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dq_oe | output | 1 | Data output drive enable |

## Verification
A corrupted burst count or latched order shows on `dout` on the very next read edge: the wrong word of the four appears. A stuck active flag shows as `dq_oe` staying high one edge past a deselect or sleep, or as a missing word after a start. A wrong lane mask cannot be seen during the write itself. It appears as mixed lanes on the first read of that address, which the bench performs on the edge after the write.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int LANE_W = 9;
  localparam int SEL_W  = 4;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_low(input logic [1:0] first,
                                           input logic [1:0] cnt,
                                           input burst_order_e ord);
    return (ord == ORD_LINEAR) ? first + cnt : first ^ cnt;
  endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          astb_cpu_n,
  input  logic          astb_ctl_n,
  input  logic          adv_n,
  input  logic          order_lin,
  input  logic          sleep,
  output logic          active,
  output logic          start,
  output logic          stop,
  output logic [AW-1:0] cur_addr
);

  logic          strobe;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  burst_order_e  ord_q;

  assign strobe = ~astb_cpu_n | ~astb_ctl_n;
  assign start  = strobe & ~ce_n & ~sleep;
  assign stop   = sleep | (strobe & ce_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
      ord_q  <= ORD_INTERLEAVE;
    end else if (stop) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      base_q <= addr;
      cnt_q  <= 2'd0;
      ord_q  <= burst_order_e'(order_lin);
    end else if (active && !adv_n) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_q, ord_q)};

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cur_addr == $past(addr))); // R2

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    (active && !start && !stop && adv_n) |=> $stable(cur_addr)); // R3

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (active && !start && !stop) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]))); // R4

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && !start && !stop && !adv_n && ord_q == ORD_LINEAR)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R4

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !active); // R12

endmodule

// File: rtl/burst_sram_wdec.sv
module burst_sram_wdec
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [SEL_W-1:0] bsel_n,
  output logic [LANES-1:0] lane_we,
  output logic             is_write
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = ~gw_n | (~bwe_n & ~bsel_n[i]);
  end

  if (LANES < SEL_W) begin : g_spare
    logic unused_sel;
    assign unused_sel = &{1'b0, bsel_n[SEL_W-1:LANES]};
  end

  assign is_write = |lane_we;

endmodule

// File: rtl/burst_sram_mem.sv
module burst_sram_mem
  import burst_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] we,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  output logic [DW-1:0]    rdata_q
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i]) mem_q[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    if (re) rdata_q <= mem_q[addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             ce_n,
  input  logic             astb_cpu_n,
  input  logic             astb_ctl_n,
  input  logic             adv_n,
  input  logic             order_lin,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [SEL_W-1:0] bsel_n,
  input  logic             sleep,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_oe
);

  localparam int LANES = DW / LANE_W;

  logic             active;
  logic             start;
  logic             stop;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] lane_we;
  logic             is_write;
  logic             valid_q;

  burst_sram_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .ce_n       (ce_n),
    .astb_cpu_n (astb_cpu_n),
    .astb_ctl_n (astb_ctl_n),
    .adv_n      (adv_n),
    .order_lin  (order_lin),
    .sleep      (sleep),
    .active     (active),
    .start      (start),
    .stop       (stop),
    .cur_addr   (cur_addr)
  );

  burst_sram_wdec #(.LANES(LANES)) u_wdec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .lane_we  (lane_we),
    .is_write (is_write)
  );

  burst_sram_mem #(.AW(AW), .LANES(LANES)) u_mem (
    .clk     (clk),
    .addr    (cur_addr),
    .we      (lane_we & {LANES{active}}),
    .wdata   (din),
    .re      (active & ~is_write),
    .rdata_q (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= active & ~is_write;
  end

  assign dq_oe = valid_q & ~oe_n;

  AST_GW_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (active && !gw_n) |=> !valid_q); // R14

  AST_DESEL_DROP: assert property (@(posedge clk) disable iff (rst)
    (stop && !rst) |=> ##1 !valid_q); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> ##1 !valid_q); // R1

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr;
  logic        ce_n, astb_cpu_n, astb_ctl_n, adv_n, order_lin;
  logic        gw_n, bwe_n, sleep, oe_n;
  logic [3:0]  bsel_n;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dq_oe;
  logic [17:0] dout18;
  logic        dq_oe18;

  logic [35:0] exp_mem [256];
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_sram #(.AW(8), .DW(36)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n),
    .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .adv_n(adv_n),
    .order_lin(order_lin), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .sleep(sleep), .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  burst_sram #(.AW(8), .DW(18)) u_dut18 (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n),
    .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .adv_n(adv_n),
    .order_lin(order_lin), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .sleep(sleep), .oe_n(oe_n), .din(din[17:0]), .dout(dout18), .dq_oe(dq_oe18)
  );

  function automatic logic [7:0] baddr(input logic [7:0] b, input int k, input logic lin);
    logic [1:0] kk;
    kk = 2'(k);
    return lin ? {b[7:2], 2'(b[1:0] + kk)} : {b[7:2], b[1:0] ^ kk};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    astb_cpu_n = 1'b1; astb_ctl_n = 1'b1; ce_n = 1'b0; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; sleep = 1'b0; oe_n = 1'b0;
  endtask

  task automatic begin_acc(input logic [7:0] a, input logic lin, input logic use_cpu);
    addr = a; order_lin = lin;
    if (use_cpu) astb_cpu_n = 1'b0; else astb_ctl_n = 1'b0;
    step();
    astb_cpu_n = 1'b1; astb_ctl_n = 1'b1;
  endtask

  task automatic desel();
    gw_n = 1'b1; bwe_n = 1'b1; adv_n = 1'b1;
    astb_ctl_n = 1'b0; ce_n = 1'b1;
    step();
    astb_ctl_n = 1'b1; ce_n = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); addr = '0; order_lin = 1'b0; din = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 dq_oe after reset", 36'(dq_oe), 36'd0);
    step();
    chk("R1 dq_oe idle", 36'(dq_oe), 36'd0);
  endtask

  task automatic t_burst(input logic [7:0] b, input logic lin, input logic use_cpu);
    begin_acc(b, lin, use_cpu);
    gw_n = 1'b0; adv_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      din = {b, 28'h5A50000 + 28'(k)};
      step();
      exp_mem[baddr(b, k, lin)] = din;
      chk("R14 no drive on write", 36'(dq_oe), 36'd0);
    end
    desel();
    begin_acc(b, lin, ~use_cpu);
    order_lin = ~lin;
    adv_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk(lin ? "R4 linear word" : "R5 interleaved word", dout, exp_mem[baddr(b, k, lin)]);
      chk("R2 drive on read", 36'(dq_oe), 36'd1);
    end
    desel();
  endtask

  task automatic t_hold();
    begin_acc(8'h15, 1'b1, 1'b1);
    step();
    chk("R2 first word", dout, exp_mem[8'h15]);
    step();
    chk("R3 held word", dout, exp_mem[8'h15]);
    adv_n = 1'b0;
    step();
    chk("R3 held until advance edge", dout, exp_mem[8'h15]);
    step();
    chk("R3 advanced word", dout, exp_mem[8'h16]);
    desel();
  endtask

  task automatic t_gw();
    begin_acc(8'h40, 1'b0, 1'b0);
    gw_n = 1'b0; bwe_n = 1'b1; bsel_n = 4'hF; din = 36'h1_2345_6789;
    step();
    exp_mem[8'h40] = din;
    gw_n = 1'b1; din = 36'h0;
    step();
    chk("R6 global write", dout, 36'h1_2345_6789);
    begin_acc(8'h40, 1'b0, 1'b1);
    gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b0101; din = 36'hF_EDCB_A987;
    step();
    exp_mem[8'h40] = din;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    step();
    chk("R6 global write overrides lane selects", dout, 36'hF_EDCB_A987);
    desel();
  endtask

  task automatic t_bytes();
    logic [35:0] oldv, newv, mask, merged;
    oldv = exp_mem[8'h40];
    newv = 36'h0_3C3C_3C3C;
    mask = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    merged = (oldv & ~mask) | (newv & mask);
    begin_acc(8'h40, 1'b0, 1'b1);
    bwe_n = 1'b0; bsel_n = 4'b1010; din = newv;
    step();
    exp_mem[8'h40] = merged;
    bwe_n = 1'b1; bsel_n = 4'b0000; din = 36'h0;
    step();
    chk("R7 lanes 0 and 2 written", dout, merged);
    bwe_n = 1'b0; bsel_n = 4'hF;
    step();
    chk("R7 no lane selected is a read", dout, merged);
    bwe_n = 1'b1;
    step();
    chk("R7 bwe_n high kept array", dout, merged);
    desel();
  endtask

  task automatic t_late();
    gw_n = 1'b0; din = 36'hB_AD0B_AD00;
    begin_acc(8'h40, 1'b0, 1'b0);
    gw_n = 1'b1;
    step();
    chk("R9 strobes on address edge ignored", dout, exp_mem[8'h40]);
    gw_n = 1'b0; din = 36'h7_7777_0000;
    step();
    exp_mem[8'h40] = din;
    gw_n = 1'b1;
    step();
    chk("R9 write sampled on data edge", dout, 36'h7_7777_0000);
    desel();
  endtask

  task automatic t_oe();
    begin_acc(8'h15, 1'b1, 1'b1);
    step();
    chk("R10 drive with oe_n low", 36'(dq_oe), 36'd1);
    oe_n = 1'b1;
    #0.5;
    chk("R10 oe_n high drops drive", 36'(dq_oe), 36'd0);
    oe_n = 1'b0;
    #0.5;
    chk("R10 oe_n low restores drive", 36'(dq_oe), 36'd1);
    desel();
  endtask

  task automatic t_desel();
    begin_acc(8'h26, 1'b0, 1'b0);
    adv_n = 1'b0;
    step();
    chk("R11 word0 before deselect", dout, exp_mem[8'h26]);
    astb_cpu_n = 1'b0; ce_n = 1'b1;
    step();
    chk("R11 word on deselect edge", dout, exp_mem[8'h27]);
    chk("R11 drive on deselect edge", 36'(dq_oe), 36'd1);
    astb_cpu_n = 1'b1; ce_n = 1'b0;
    step();
    chk("R11 drive off after deselect", 36'(dq_oe), 36'd0);
    adv_n = 1'b1;
  endtask

  task automatic t_restart();
    begin_acc(8'h15, 1'b1, 1'b1);
    adv_n = 1'b0;
    step();
    chk("R13 first burst word0", dout, exp_mem[8'h15]);
    addr = 8'h26; order_lin = 1'b1; astb_ctl_n = 1'b0;
    step();
    astb_ctl_n = 1'b1;
    chk("R13 old word on restart edge", dout, exp_mem[8'h16]);
    step();
    chk("R13 new start word", dout, exp_mem[8'h26]);
    step();
    chk("R13 new burst linear next", dout, exp_mem[8'h27]);
    desel();
  endtask

  task automatic t_sleep();
    begin_acc(8'h40, 1'b0, 1'b0);
    step();
    sleep = 1'b1;
    step();
    chk("R12 word on sleep edge", 36'(dq_oe), 36'd1);
    step();
    chk("R12 drive off while asleep", 36'(dq_oe), 36'd0);
    begin_acc(8'h40, 1'b0, 1'b1);
    step();
    chk("R12 no start while asleep", 36'(dq_oe), 36'd0);
    sleep = 1'b0;
    begin_acc(8'h40, 1'b0, 1'b1);
    step();
    chk("R12 contents kept", dout, exp_mem[8'h40]);
    desel();
  endtask

  task automatic t_w18();
    begin_acc(8'h70, 1'b0, 1'b0);
    gw_n = 1'b0; din = 36'h0_0001_2345;
    step();
    gw_n = 1'b1;
    step();
    chk("R8 narrow global write", 36'(dout18), 36'(18'h1_2345));
    bwe_n = 1'b0; bsel_n = 4'b0011; din = 36'h0_0003_FFFF;
    step();
    bwe_n = 1'b1; bsel_n = 4'hF;
    step();
    chk("R8 upper selects ignored", 36'(dout18), 36'(18'h1_2345));
    chk("R8 upper selects gives read", 36'(dq_oe18), 36'd1);
    bwe_n = 1'b0; bsel_n = 4'b1110; din = 36'h0_0000_00AA;
    step();
    bwe_n = 1'b1; bsel_n = 4'hF;
    step();
    chk("R8 narrow lane0 write", 36'(dout18), 36'({9'h091, 9'h0AA}));
    desel();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    t_reset();
    t_burst(8'h15, 1'b1, 1'b1);
    t_burst(8'h26, 1'b0, 1'b0);
    t_burst(8'h33, 1'b0, 1'b1);
    t_hold();
    t_gw();
    t_bytes();
    t_late();
    t_oe();
    t_desel();
    t_restart();
    t_sleep();
    t_w18();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule